// File: doc/BRIEF.md
# Accumulator Arithmetic Instruction Unit

This block carries out one register-to-register arithmetic or logic instruction for a 16-bit machine with four accumulators and one carry bit. The caller presents the instruction word, the four accumulator values and the present carry, and raises a valid strobe for one cycle. On the next clock edge the block reports a registered result: the new destination value, the destination index, the new carry, write enables for the accumulator and for the carry, and a skip flag. A one-cycle done pulse marks the result.

A single word selects everything. It names the operand accumulators, one of eight operations and a base carry, and the word's low bits apply them in a fixed order. A carry-out from the 16-bit operation complements the base carry. A rotate through carry or a byte swap may follow. A skip test then looks at the final carry and result. A no-load option still reports the skip but writes nothing back. Words that are not arithmetic instructions are refused with an illegal flag. Instruction fetch, memory and the program counter belong to the caller, which applies the write enables and acts on the skip flag.

Top module: `acc_alu_unit`

## Requirements
- R1: A word with bit 15 set is an arithmetic instruction. Bits 14:13 select the source accumulator, bits 12:11 the destination accumulator (reported on `out_dst`) and bits 10:8 the operation. The result appears with `out_done` high in the cycle after `in_valid` was high.
- R2: The operation codes (S = source, D = destination) are 0 = NOT S, 1 = negate S, 2 = S, 3 = S+1, 4 = D + NOT S, 5 = D - S (computed as D + NOT S + 1), 6 = D + S and 7 = D AND S. Results are taken modulo 2^16.
- R3: Bits 5:4 choose the base carry: 0 = present carry, 1 = zero, 2 = one, 3 = inverted present carry.
- R4: A carry out of bit 15 of the operation inverts the base carry. Only codes 1, 3, 4, 5 and 6 can produce one. Codes 0, 2 and 7 never do.
- R5: Bits 7:6 choose a post-operation shift of the 17-bit value {carry, result}: 0 = none, 1 = rotate left (the carry enters bit 0 and bit 15 becomes the carry), 2 = rotate right (the carry enters bit 15 and bit 0 becomes the carry), 3 = swap the two bytes of the result and leave the carry as it is.
- R6: Bits 2:0 choose the skip test on the carry and result after the shift: 0 never, 1 always, 2 carry zero, 3 carry one, 4 result zero, 5 result nonzero, 6 carry zero or result zero, 7 carry one and result nonzero.
- R7: When bit 3 (no-load) is set, `out_wr_acc` and `out_wr_carry` stay low, while the value, carry and skip are still reported. When bit 3 is clear, both enables are high.
- R8: The operands are the accumulator values and carry sampled on the accepting clock edge. The destination may equal the source, and later input changes do not alter the reported result.
- R9: A word with bit 15 clear gives `out_done` with `out_illegal` high, both write enables low, `out_skip` low, and a value and carry of zero.
- R10: Synchronous active-high reset clears every output to zero.
- R11: `out_done` pulses exactly once for each accepted strobe and never without one. Illegal, enable and skip outputs are low whenever `out_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the instruction on this edge |
| instr | input | 16 | Instruction word |
| acc_bus | input | 4*DATA_W | Accumulators; accumulator k at bits [k*DATA_W +: DATA_W] |
| carry_in | input | 1 | Present carry |
| out_done | output | 1 | Result valid pulse |
| out_illegal | output | 1 | Word was not an arithmetic instruction |
| out_wr_acc | output | 1 | Write `out_value` to accumulator `out_dst` |
| out_wr_carry | output | 1 | Write `out_carry` to the carry |
| out_dst | output | 2 | Destination accumulator index |
| out_value | output | DATA_W | New destination value |
| out_carry | output | 1 | New carry |
| out_skip | output | 1 | Skip condition result |

## Verification
The bench builds the block with its default width, DATA_W = 16. At this width the 16-bit carry-out boundaries (0xFFFF + 1, negating zero, subtracting equal values) and the one-byte swap are reached directly. Directed sweeps cover every shift with carry 0 and 1, every base-carry mode with carrying and non-carrying operations, and all eight skip codes on zero and nonzero results. A pseudo-random run of words, operand values and carries, with the no-load bit and bit 15 mixed in, then reaches combinations of these.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int INSTR_W = 16;
  localparam int IDX_W   = 2;
  localparam int NUM_ACC = 1 << IDX_W;

  typedef enum logic [2:0] {
    OP_NOT, OP_NEG, OP_MOV, OP_INC, OP_ADDN, OP_SUB, OP_ADD, OP_AND
  } alu_op_e;

  typedef enum logic [1:0] {SH_NONE, SH_ROL, SH_ROR, SH_SWAP} shift_e;

  typedef enum logic [1:0] {CB_KEEP, CB_ZERO, CB_ONE, CB_FLIP} cbase_e;

  typedef enum logic [2:0] {
    SK_NEVER, SK_ALWAYS, SK_CZ, SK_CNZ, SK_RZ, SK_RNZ, SK_EITHER_Z, SK_BOTH_NZ
  } skip_e;

  typedef struct packed {
    logic             arith;
    logic [IDX_W-1:0] src;
    logic [IDX_W-1:0] dst;
    alu_op_e          op;
    shift_e           sh;
    cbase_e           cb;
    logic             noload;
    skip_e            sk;
  } fields_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output fields_t            f
);
  always_comb begin
    f.arith  = word[15];
    f.src    = word[14:13];
    f.dst    = word[12:11];
    f.op     = alu_op_e'(word[10:8]);
    f.sh     = shift_e'(word[7:6]);
    f.cb     = cbase_e'(word[5:4]);
    f.noload = word[3];
    f.sk     = skip_e'(word[2:0]);
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  cbase_e            cb,
  input  logic [DATA_W-1:0] d_val,
  input  logic [DATA_W-1:0] s_val,
  input  logic              c_cur,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};

  logic            base;
  logic [DATA_W:0] sum;
  logic [DATA_W:0] d_ext;
  logic [DATA_W:0] s_ext;
  logic [DATA_W:0] sn_ext;

  always_comb begin
    d_ext  = {1'b0, d_val};
    s_ext  = {1'b0, s_val};
    sn_ext = {1'b0, ~s_val};
    unique case (cb)
      CB_KEEP: base = c_cur;
      CB_ZERO: base = 1'b0;
      CB_ONE:  base = 1'b1;
      default: base = ~c_cur;
    endcase
    unique case (op)
      OP_NOT:  sum = sn_ext;
      OP_NEG:  sum = sn_ext + ONE;
      OP_MOV:  sum = s_ext;
      OP_INC:  sum = s_ext + ONE;
      OP_ADDN: sum = d_ext + sn_ext;
      OP_SUB:  sum = d_ext + sn_ext + ONE;
      OP_ADD:  sum = d_ext + s_ext;
      default: sum = {1'b0, d_val & s_val};
    endcase
    res   = sum[DATA_W-1:0];
    c_out = base ^ sum[DATA_W];
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  shift_e            sh,
  input  logic [DATA_W-1:0] r_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] r_out,
  output logic              c_out
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    unique case (sh)
      SH_ROL: begin
        r_out = {r_in[DATA_W-2:0], c_in};
        c_out = r_in[DATA_W-1];
      end
      SH_ROR: begin
        r_out = {c_in, r_in[DATA_W-1:1]};
        c_out = r_in[0];
      end
      SH_SWAP: begin
        r_out = {r_in[HALF-1:0], r_in[DATA_W-1:HALF]};
        c_out = c_in;
      end
      default: begin
        r_out = r_in;
        c_out = c_in;
      end
    endcase
  end
endmodule

// File: rtl/acc_alu_skip.sv
module acc_alu_skip
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  skip_e             sk,
  input  logic [DATA_W-1:0] r,
  input  logic              c,
  output logic              skip
);
  logic rz;

  always_comb begin
    rz = (r == '0);
    unique case (sk)
      SK_NEVER:    skip = 1'b0;
      SK_ALWAYS:   skip = 1'b1;
      SK_CZ:       skip = ~c;
      SK_CNZ:      skip = c;
      SK_RZ:       skip = rz;
      SK_RNZ:      skip = ~rz;
      SK_EITHER_Z: skip = ~c | rz;
      default:     skip = c & ~rz;
    endcase
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [15:0]               instr,
  input  logic [4*DATA_W-1:0]       acc_bus,
  input  logic                      carry_in,
  output logic                      out_done,
  output logic                      out_illegal,
  output logic                      out_wr_acc,
  output logic                      out_wr_carry,
  output logic [1:0]                out_dst,
  output logic [DATA_W-1:0]         out_value,
  output logic                      out_carry,
  output logic                      out_skip
);
  fields_t           f;
  logic [DATA_W-1:0] acc_arr [NUM_ACC];
  logic [DATA_W-1:0] op_res;
  logic              op_c;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic              sk_hit;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_unpack
    assign acc_arr[g] = acc_bus[g*DATA_W +: DATA_W];
  end

  acc_alu_decode u_dec (.word(instr), .f(f));

  acc_alu_core #(.DATA_W(DATA_W)) u_core (
    .op(f.op), .cb(f.cb), .d_val(acc_arr[f.dst]), .s_val(acc_arr[f.src]),
    .c_cur(carry_in), .res(op_res), .c_out(op_c)
  );

  acc_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .sh(f.sh), .r_in(op_res), .c_in(op_c), .r_out(sh_res), .c_out(sh_c)
  );

  acc_alu_skip #(.DATA_W(DATA_W)) u_skip (
    .sk(f.sk), .r(sh_res), .c(sh_c), .skip(sk_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done     <= 1'b0;
      out_illegal  <= 1'b0;
      out_wr_acc   <= 1'b0;
      out_wr_carry <= 1'b0;
      out_dst      <= '0;
      out_value    <= '0;
      out_carry    <= 1'b0;
      out_skip     <= 1'b0;
    end else begin
      out_done <= in_valid;
      if (in_valid && f.arith) begin
        out_illegal  <= 1'b0;
        out_wr_acc   <= ~f.noload;
        out_wr_carry <= ~f.noload;
        out_dst      <= f.dst;
        out_value    <= sh_res;
        out_carry    <= sh_c;
        out_skip     <= sk_hit;
      end else if (in_valid) begin
        out_illegal  <= 1'b1;
        out_wr_acc   <= 1'b0;
        out_wr_carry <= 1'b0;
        out_dst      <= f.dst;
        out_value    <= '0;
        out_carry    <= 1'b0;
        out_skip     <= 1'b0;
      end else begin
        out_illegal  <= 1'b0;
        out_wr_acc   <= 1'b0;
        out_wr_carry <= 1'b0;
        out_skip     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [15:0]       instr,
  input logic              out_done,
  input logic              out_illegal,
  input logic              out_wr_acc,
  input logic              out_wr_carry,
  input logic [DATA_W-1:0] out_value,
  input logic              out_carry,
  input logic              out_skip
);
  logic legal_v;
  assign legal_v = in_valid && instr[15];

  // R1: result follows an accepted strobe by one cycle
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done);

  // R11: no pulse and no flags without a strobe
  assert_no_stray_done_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_done && !out_illegal && !out_wr_acc && !out_wr_carry && !out_skip));

  // R7: no-load suppresses both writes
  assert_noload_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[3]) |=> (!out_wr_acc && !out_wr_carry));

  assert_load_enables_R7: assert property (@(posedge clk) disable iff (rst)
    (legal_v && !instr[3]) |=> (out_wr_acc && out_wr_carry));

  // R9: non-arithmetic words are refused
  assert_illegal_refused_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[15]) |=> (out_illegal && !out_wr_acc && !out_wr_carry && !out_skip));

  // R6: skip tests on reported values
  assert_skip_never_R6: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[2:0] == 3'd0) |=> !out_skip);

  assert_skip_always_R6: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[2:0] == 3'd1) |=> out_skip);

  assert_skip_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[2:0] == 3'd2) |=> (out_skip == !out_carry));

  assert_skip_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[2:0] == 3'd4) |=> (out_skip == (out_value == '0)));

  // R3 and R4: forced base with a non-carrying op and a byte swap keeps it
  assert_forced_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[5:4] == 2'd1 && instr[7:6] == 2'd3 &&
     (instr[10:8] == 3'd0 || instr[10:8] == 3'd2 || instr[10:8] == 3'd7)) |=> !out_carry);

  assert_forced_one_R4: assert property (@(posedge clk) disable iff (rst)
    (legal_v && instr[5:4] == 2'd2 && instr[7:6] == 2'd3 &&
     (instr[10:8] == 3'd0 || instr[10:8] == 3'd2 || instr[10:8] == 3'd7)) |=> out_carry);

  // R10: reset clears outputs
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!out_done && !out_illegal && !out_wr_acc && !out_skip && out_value == '0 && !out_carry));
endmodule

bind acc_alu_unit acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
  .out_done(out_done), .out_illegal(out_illegal), .out_wr_acc(out_wr_acc),
  .out_wr_carry(out_wr_carry), .out_value(out_value), .out_carry(out_carry),
  .out_skip(out_skip)
);

// File: tb/sim_acc_alu_unit.sv
`timescale 1ns/1ps
module sim_acc_alu_unit;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [15:0]   instr = '0;
  logic [4*W-1:0] acc_bus = '0;
  logic          carry_in = 1'b0;
  logic          out_done, out_illegal, out_wr_acc, out_wr_carry;
  logic [1:0]    out_dst;
  logic [W-1:0]  out_value;
  logic          out_carry, out_skip;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  acc_alu_unit #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .acc_bus(acc_bus),
    .carry_in(carry_in), .out_done(out_done), .out_illegal(out_illegal),
    .out_wr_acc(out_wr_acc), .out_wr_carry(out_wr_carry), .out_dst(out_dst),
    .out_value(out_value), .out_carry(out_carry), .out_skip(out_skip)
  );

  typedef struct {
    logic         illegal;
    logic         wr_acc;
    logic         wr_carry;
    logic [1:0]   dst;
    logic [W-1:0] value;
    logic         carry;
    logic         skip;
    string        tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic logic [15:0] mk(input logic [1:0] src, input logic [1:0] dst,
                                     input logic [2:0] op, input logic [1:0] sh,
                                     input logic [1:0] cb, input logic nl,
                                     input logic [2:0] sk);
    return {1'b1, src, dst, op, sh, cb, nl, sk};
  endfunction

  function automatic exp_t model(input logic [15:0] w, input logic [4*W-1:0] bus,
                                 input logic c, input string tag);
    exp_t e;
    logic [W-1:0] s, d, r;
    logic [W:0]   t;
    logic         base, cc, rz;
    e.tag = tag;
    e.dst = w[12:11];
    if (!w[15]) begin
      e.illegal = 1; e.wr_acc = 0; e.wr_carry = 0; e.value = '0; e.carry = 0; e.skip = 0;
      return e;
    end
    s = bus[w[14:13]*W +: W];
    d = bus[w[12:11]*W +: W];
    case (w[5:4])
      2'd0: base = c;
      2'd1: base = 0;
      2'd2: base = 1;
      default: base = !c;
    endcase
    case (w[10:8])
      3'd0: t = {1'b0, ~s};
      3'd1: t = {1'b0, ~s} + 17'd1;
      3'd2: t = {1'b0, s};
      3'd3: t = {1'b0, s} + 17'd1;
      3'd4: t = {1'b0, d} + {1'b0, ~s};
      3'd5: t = {1'b0, d} + {1'b0, ~s} + 17'd1;
      3'd6: t = {1'b0, d} + {1'b0, s};
      default: t = {1'b0, d & s};
    endcase
    r  = t[W-1:0];
    cc = base ^ t[W];
    case (w[7:6])
      2'd1: begin e.value = {r[W-2:0], cc}; e.carry = r[W-1]; end
      2'd2: begin e.value = {cc, r[W-1:1]}; e.carry = r[0]; end
      2'd3: begin e.value = {r[7:0], r[15:8]}; e.carry = cc; end
      default: begin e.value = r; e.carry = cc; end
    endcase
    rz = (e.value == '0);
    case (w[2:0])
      3'd0: e.skip = 0;
      3'd1: e.skip = 1;
      3'd2: e.skip = !e.carry;
      3'd3: e.skip = e.carry;
      3'd4: e.skip = rz;
      3'd5: e.skip = !rz;
      3'd6: e.skip = !e.carry || rz;
      default: e.skip = e.carry && !rz;
    endcase
    e.illegal = 0;
    e.wr_acc = !w[3];
    e.wr_carry = !w[3];
    return e;
  endfunction

  task automatic send(input logic [15:0] w, input logic [4*W-1:0] bus,
                      input logic c, input string tag);
    @(negedge clk);
    in_valid = 1; instr = w; acc_bus = bus; carry_in = c;
    exp_q.push_back(model(w, bus, c, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      instr = 16'hFFFF;
      acc_bus = {4{16'hA5C3}};
      carry_in = ~carry_in;
    end
  endtask

  function automatic logic [4*W-1:0] accs(input logic [W-1:0] a0, input logic [W-1:0] a1,
                                          input logic [W-1:0] a2, input logic [W-1:0] a3);
    return {a3, a2, a1, a0};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished && out_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 done without strobe: got done=1 expected done=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_illegal !== e.illegal || out_wr_acc !== e.wr_acc ||
            out_wr_carry !== e.wr_carry || out_skip !== e.skip ||
            (!e.illegal && (out_dst !== e.dst)) ||
            out_value !== e.value || out_carry !== e.carry) begin
          errors++;
          $display("FAIL %s got ill=%0b wa=%0b wc=%0b dst=%0d val=%h c=%0b sk=%0b expected ill=%0b wa=%0b wc=%0b dst=%0d val=%h c=%0b sk=%0b",
                   e.tag, out_illegal, out_wr_acc, out_wr_carry, out_dst, out_value,
                   out_carry, out_skip, e.illegal, e.wr_acc, e.wr_carry, e.dst,
                   e.value, e.carry, e.skip);
        end
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    checks++;
    if (out_done !== 0 || out_illegal !== 0 || out_wr_acc !== 0 || out_wr_carry !== 0 ||
        out_value !== '0 || out_carry !== 0 || out_skip !== 0 || out_dst !== 0) begin
      errors++;
      $display("FAIL R10 reset: got done=%0b val=%h c=%0b expected all zero",
               out_done, out_value, out_carry);
    end
    rst = 0;
    idle(2);

    // R1 / R2: operand routing and each operation
    send(mk(2'd1, 2'd2, 3'd0, 2'd0, 2'd0, 0, 3'd0), accs(16'h0000, 16'h1234, 16'h0F0F, 16'h0), 0, "R2 not");
    send(mk(2'd3, 2'd0, 3'd1, 2'd0, 2'd0, 0, 3'd4), accs(16'h0, 16'h0, 16'h0, 16'h0000), 0, "R4 neg zero");
    send(mk(2'd3, 2'd0, 3'd1, 2'd0, 2'd0, 0, 3'd0), accs(16'h0, 16'h0, 16'h0, 16'h0005), 0, "R2 neg");
    send(mk(2'd2, 2'd1, 3'd2, 2'd0, 2'd0, 0, 3'd0), accs(16'h0, 16'h0, 16'hBEEF, 16'h0), 1, "R1 mov");
    send(mk(2'd0, 2'd0, 3'd3, 2'd0, 2'd0, 0, 3'd6), accs(16'hFFFF, 16'h0, 16'h0, 16'h0), 0, "R8 inc self");
    send(mk(2'd1, 2'd3, 3'd4, 2'd0, 2'd0, 0, 3'd0), accs(16'h0, 16'h0003, 16'h0, 16'h0009), 0, "R2 addn");
    send(mk(2'd1, 2'd1, 3'd5, 2'd0, 2'd0, 0, 3'd4), accs(16'h0, 16'h0005, 16'h0, 16'h0), 0, "R8 sub self");
    send(mk(2'd0, 2'd1, 3'd5, 2'd0, 2'd1, 0, 3'd2), accs(16'h0009, 16'h0004, 16'h0, 16'h0), 1, "R4 sub borrow");
    send(mk(2'd2, 2'd3, 3'd6, 2'd0, 2'd1, 0, 3'd6), accs(16'h0, 16'h0, 16'h0001, 16'hFFFF), 0, "R4 add wrap");
    send(mk(2'd0, 2'd2, 3'd7, 2'd0, 2'd0, 0, 3'd5), accs(16'hF0F0, 16'h0, 16'h3C3C, 16'h0), 1, "R2 and");
    idle(3);
    // R11: idle cycles carry no pulse
    checks++;
    if (out_done !== 0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 idle: got done=%0b pending=%0d expected done=0 pending=0",
               out_done, exp_q.size());
    end

    // R5: every shift with both carry values
    for (int sh = 0; sh < 4; sh++)
      for (int c = 0; c < 2; c++)
        send(mk(2'd1, 2'd0, 3'd2, sh[1:0], 2'd0, 0, 3'd0), accs(16'h0, 16'h8181, 16'h0, 16'h0), c[0], "R5 shift");

    // R3 / R4: base modes with non-carrying and carrying operations
    for (int cb = 0; cb < 4; cb++)
      for (int c = 0; c < 2; c++) begin
        send(mk(2'd1, 2'd0, 3'd2, 2'd3, cb[1:0], 0, 3'd0), accs(16'h0, 16'h1200, 16'h0, 16'h0), c[0], "R3 base");
        send(mk(2'd1, 2'd0, 3'd3, 2'd0, cb[1:0], 0, 3'd0), accs(16'h0, 16'hFFFF, 16'h0, 16'h0), c[0], "R4 carry flip");
      end

    // R6: every skip code on zero and nonzero results
    for (int sk = 0; sk < 8; sk++) begin
      send(mk(2'd1, 2'd2, 3'd6, 2'd0, 2'd0, 0, sk[2:0]), accs(16'h0, 16'h0001, 16'hFFFF, 16'h0), 0, "R6 skip zero");
      send(mk(2'd1, 2'd2, 3'd6, 2'd0, 2'd0, 0, sk[2:0]), accs(16'h0, 16'h0001, 16'h0010, 16'h0), 0, "R6 skip nz");
      send(mk(2'd1, 2'd2, 3'd2, 2'd1, 2'd2, 0, sk[2:0]), accs(16'h0, 16'h8000, 16'h0, 16'h0), 0, "R6 skip post shift");
    end
    idle(1);

    // R7: no-load keeps enables low while skip still reported
    send(mk(2'd1, 2'd2, 3'd6, 2'd0, 2'd0, 1, 3'd4), accs(16'h0, 16'h0001, 16'hFFFF, 16'h0), 0, "R7 noload");
    send(mk(2'd0, 2'd3, 3'd0, 2'd2, 2'd3, 1, 3'd1), accs(16'h1357, 16'h0, 16'h0, 16'h0), 1, "R7 noload always");
    // R9: illegal words
    send(16'h4000, accs(16'h1, 16'h2, 16'h3, 16'h4), 1, "R9 illegal");
    send(16'h7FFF, accs(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF), 0, "R9 illegal ones");
    idle(2);

    // R2: pseudo-random mix
    for (int i = 0; i < 300; i++) begin
      logic [4*W-1:0] bus;
      logic [15:0] w;
      for (int k = 0; k < 5; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (k < 4) bus[k*W +: W] = lfsr ^ 16'(k * 16'h1111);
        else w = lfsr;
      end
      if (i % 9 != 0) w[15] = 1'b1;
      send(w, bus, lfsr[3], "R2 random");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing results: got pending=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule